// File: doc/BRIEF.md
# Load Value Predictor with Confidence Classifier

This block guesses the data a load will return before the memory access finishes, and it also decides whether that guess is safe to use. It keeps two untagged, direct-mapped tables. Both are selected by the same slice of the load's instruction address. The value table holds the last data seen for each slot. The confidence table holds a 2-bit saturating counter for each slot, and that counter sorts the load into one of four classes: cold, warm, predictable or constant. A lookup is purely combinational. It returns the stored value, a flag that says to use it, and a flag that says the load may skip verification.

When a load completes, the pipeline reports its address and the actual data on the verify port. The block compares the data with the value stored before this update and moves the counter up on a match or down on a miss. It then overwrites the stored value. A store that hits a location treated as constant is reported on the invalidate port. That report drops the slot's counter to the warm state.

After reset, a sweep state machine spends one cycle on each slot to clear both tables. It then raises `ready`. Until then the lookup outputs read as zero and updates are ignored. The sweep state machine has two states. `INIT_SWEEP` is entered on reset. The transition `SWEEP_END` happens on the cycle that clears the last slot and leads to `INIT_DONE`, which holds until the next reset. The counter classes form the second state machine. Its transitions are: `HIT_UP` (one class higher, saturating at constant), `MISS_DOWN` (one class lower, saturating at cold), `KILL` (forced to warm by an invalidate) and `WIPE` (forced to cold by the sweep).

Top module: `load_value_predictor`

## Requirements
- R1: The slot index is instruction-address bits [9:2], and the tables hold no tag. Two addresses that differ only outside those bits read and update the same slot.
- R2: An accepted verify always writes its data into the slot's value entry. The next lookup of that slot returns that data.
- R3: An accepted verify compares its data with the value stored before the write. A match raises the counter by one, saturating at 3. A mismatch lowers it by one, saturating at 0.
- R4: The use flag is 1 exactly when the counter is 2 or 3. The constant flag is 1 exactly when the counter is 3. Counter 0 is cold and counter 1 is warm; both predict nothing.
- R5: An update to one slot leaves the value and counter of every other slot unchanged.
- R6: An accepted invalidate forces its slot's counter to 1. The invalidate takes priority over a verify to the same slot in the same cycle, but that verify's value write still happens.
- R7: After reset is released, `ready` stays 0 for exactly 256 rising edges and is 1 from the 256th on. At that point every value is 0 and every counter is 0.
- R8: While `ready` is 0, the lookup outputs are all zero, and verify and invalidate requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the sweep state machine |
| ready | output | 1 | Tables cleared and block accepting updates |
| lk_pc | input | 32 | Instruction address of the load being looked up |
| lk_value | output | 32 | Predicted load data |
| lk_use | output | 1 | Prediction is confident enough to use |
| lk_const | output | 1 | Load is classed constant; verification may be skipped |
| vf_valid | input | 1 | Verify request |
| vf_pc | input | 32 | Instruction address of the completed load |
| vf_value | input | 32 | Actual data the load returned |
| inv_valid | input | 1 | Invalidate request |
| inv_pc | input | 32 | Instruction address of the load whose constant status is revoked |

## Verification
The bound checker watches the rules that hold on every cycle:
- the constant flag never appears without the use flag;
- the outputs stay quiet while the sweep runs, and `ready` never drops once it is set;
- a slot just written by a verify reads back that data;
- a slot just invalidated never asks for its prediction to be used.

Some behaviour can only be shown by the bench's scenarios, which compare every touched slot against a model kept in the bench:
- the counter climbing and falling, including saturation at both ends;
- aliasing between addresses that share an index;
- the exact length of the clearing sweep;
- the priority of an invalidate over a verify to the same slot in the same cycle.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    // Confidence class held per slot (encoding is observable through lk_use/lk_const)
    typedef enum logic [1:0] {
        CLS_COLD  = 2'd0,
        CLS_WARM  = 2'd1,
        CLS_PRED  = 2'd2,
        CLS_CONST = 2'd3
    } cls_e;

    // Table clearing sequencer
    typedef enum logic {
        INIT_SWEEP = 1'b0,
        INIT_DONE  = 1'b1
    } init_e;

    // Next class after a verify: HIT_UP or MISS_DOWN, saturating
    function automatic cls_e cls_step(input cls_e cur, input logic hit);
        cls_e nxt;
        unique case (cur)
            CLS_COLD:  nxt = hit ? CLS_WARM  : CLS_COLD;
            CLS_WARM:  nxt = hit ? CLS_PRED  : CLS_COLD;
            CLS_PRED:  nxt = hit ? CLS_CONST : CLS_WARM;
            CLS_CONST: nxt = hit ? CLS_CONST : CLS_PRED;
            default:   nxt = CLS_COLD;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lvp_init_fsm.sv
module lvp_init_fsm
    import lvp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sweep,
    output logic [IDX_W-1:0] sweep_idx,
    output logic             ready
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    init_e            state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_SWEEP;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Transitions: SWEEP_END on the last slot
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            INIT_SWEEP: begin
                ptr_d = ptr_q + 1'b1;
                if (ptr_q == LAST_IDX) begin
                    state_d = INIT_DONE;
                end
            end
            INIT_DONE: begin
                ptr_d = ptr_q;
            end
            default: state_d = INIT_SWEEP;
        endcase
    end

    // Outputs
    always_comb begin
        sweep     = 1'b0;
        ready     = 1'b0;
        sweep_idx = ptr_q;
        unique case (state_q)
            INIT_SWEEP: sweep = 1'b1;
            INIT_DONE:  ready = 1'b1;
            default:    sweep = 1'b0;
        endcase
    end

endmodule

// File: rtl/lvp_value_table.sv
module lvp_value_table #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [VAL_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [VAL_W-1:0] rd_b_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem_q[rd_a_idx];
    assign rd_b_data = mem_q[rd_b_idx];

endmodule

// File: rtl/lvp_class_table.sv
module lvp_class_table
    import lvp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             sweep,
    input  logic [IDX_W-1:0] sweep_idx,
    input  logic             kill_en,
    input  logic [IDX_W-1:0] kill_idx,
    input  logic             vf_en,
    input  logic [IDX_W-1:0] vf_idx,
    input  logic             vf_hit,
    input  logic [IDX_W-1:0] rd_a_idx,
    output cls_e             rd_a_cls,
    input  logic [IDX_W-1:0] rd_b_idx,
    output cls_e             rd_b_cls
);

    localparam int DEPTH = 1 << IDX_W;

    cls_e cls_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
            cls_e cls_d;

            // Per-slot class transitions: WIPE > KILL > HIT_UP/MISS_DOWN
            always_comb begin
                cls_d = cls_q[g];
                if (sweep && (sweep_idx == MY_IDX)) begin
                    cls_d = CLS_COLD;
                end else if (kill_en && (kill_idx == MY_IDX)) begin
                    cls_d = CLS_WARM;
                end else if (vf_en && (vf_idx == MY_IDX)) begin
                    cls_d = cls_step(cls_q[g], vf_hit);
                end
            end

            always_ff @(posedge clk) begin
                cls_q[g] <= cls_d;
            end
        end
    endgenerate

    assign rd_a_cls = cls_q[rd_a_idx];
    assign rd_b_cls = cls_q[rd_b_idx];

endmodule

// File: rtl/load_value_predictor.sv
module load_value_predictor
    import lvp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int VAL_W   = 32,
    parameter int IDX_W   = 8,
    parameter int IDX_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ready,
    input  logic [PC_W-1:0]  lk_pc,
    output logic [VAL_W-1:0] lk_value,
    output logic             lk_use,
    output logic             lk_const,
    input  logic             vf_valid,
    input  logic [PC_W-1:0]  vf_pc,
    input  logic [VAL_W-1:0] vf_value,
    input  logic             inv_valid,
    input  logic [PC_W-1:0]  inv_pc
);

    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] lk_idx, vf_idx, inv_idx;
    logic             sweep;
    logic [IDX_W-1:0] sweep_idx;
    logic             vf_en, kill_en, vf_hit;
    logic             vt_we;
    logic [IDX_W-1:0] vt_widx;
    logic [VAL_W-1:0] vt_wdata;
    logic [VAL_W-1:0] lk_raw, vf_old;
    cls_e             lk_cls, vf_cls_unused;
    logic             unused_pc_bits;

    assign lk_idx  = lk_pc[IDX_MSB:IDX_LSB];
    assign vf_idx  = vf_pc[IDX_MSB:IDX_LSB];
    assign inv_idx = inv_pc[IDX_MSB:IDX_LSB];

    assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_MSB+1], lk_pc[IDX_LSB-1:0],
                              vf_pc[PC_W-1:IDX_MSB+1], vf_pc[IDX_LSB-1:0],
                              inv_pc[PC_W-1:IDX_MSB+1], inv_pc[IDX_LSB-1:0],
                              vf_cls_unused};

    lvp_init_fsm #(.IDX_W(IDX_W)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep     (sweep),
        .sweep_idx (sweep_idx),
        .ready     (ready)
    );

    // Updates are accepted only once the sweep has finished
    assign vf_en   = ready && vf_valid;
    assign kill_en = ready && inv_valid;
    assign vf_hit  = (vf_old == vf_value);

    assign vt_we    = sweep || vf_en;
    assign vt_widx  = sweep ? sweep_idx : vf_idx;
    assign vt_wdata = sweep ? '0 : vf_value;

    lvp_value_table #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_vals (
        .clk       (clk),
        .wr_en     (vt_we),
        .wr_idx    (vt_widx),
        .wr_data   (vt_wdata),
        .rd_a_idx  (lk_idx),
        .rd_a_data (lk_raw),
        .rd_b_idx  (vf_idx),
        .rd_b_data (vf_old)
    );

    lvp_class_table #(.IDX_W(IDX_W)) u_cls (
        .clk       (clk),
        .sweep     (sweep),
        .sweep_idx (sweep_idx),
        .kill_en   (kill_en),
        .kill_idx  (inv_idx),
        .vf_en     (vf_en),
        .vf_idx    (vf_idx),
        .vf_hit    (vf_hit),
        .rd_a_idx  (lk_idx),
        .rd_a_cls  (lk_cls),
        .rd_b_idx  (vf_idx),
        .rd_b_cls  (vf_cls_unused)
    );

    // Lookup outputs, quiet until the tables are clean
    always_comb begin
        lk_value = '0;
        lk_use   = 1'b0;
        lk_const = 1'b0;
        if (ready) begin
            lk_value = lk_raw;
            unique case (lk_cls)
                CLS_COLD, CLS_WARM: lk_use = 1'b0;
                CLS_PRED:           lk_use = 1'b1;
                CLS_CONST: begin
                    lk_use   = 1'b1;
                    lk_const = 1'b1;
                end
                default:            lk_use = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lvp_checker.sv
module lvp_checker #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic [IDX_W-1:0] lk_idx,
    input logic [VAL_W-1:0] lk_value,
    input logic             lk_use,
    input logic             lk_const,
    input logic             vf_valid,
    input logic [IDX_W-1:0] vf_idx,
    input logic [VAL_W-1:0] vf_value,
    input logic             inv_valid,
    input logic [IDX_W-1:0] inv_idx
);

    AST_CONST_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_const |-> lk_use); // R4

    AST_QUIET_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (lk_value == '0) && !lk_use && !lk_const); // R8

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R7

    AST_VERIFY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready && vf_valid) && (lk_idx == $past(vf_idx)))
        |-> (lk_value == $past(vf_value))); // R2

    AST_KILL_DROPS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready && inv_valid) && (lk_idx == $past(inv_idx)))
        |-> (!lk_use && !lk_const)); // R6

endmodule

bind load_value_predictor lvp_checker #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_lvp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .lk_idx    (lk_idx),
    .lk_value  (lk_value),
    .lk_use    (lk_use),
    .lk_const  (lk_const),
    .vf_valid  (vf_valid),
    .vf_idx    (vf_idx),
    .vf_value  (vf_value),
    .inv_valid (inv_valid),
    .inv_idx   (inv_idx)
);

// File: tb/test_load_value_predictor.sv
module test_load_value_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic [31:0] lk_pc = '0;
    logic [31:0] lk_value;
    logic        lk_use, lk_const;
    logic        vf_valid = 1'b0;
    logic [31:0] vf_pc = '0;
    logic [31:0] vf_value = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_pc = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int          cnt_m [SLOTS];
    logic [31:0] val_m [SLOTS];
    logic [31:0] lfsr = 32'h1bad_5eed;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_value_predictor i_load_value_predictor (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .lk_pc(lk_pc), .lk_value(lk_value), .lk_use(lk_use), .lk_const(lk_const),
        .vf_valid(vf_valid), .vf_pc(vf_pc), .vf_value(vf_value),
        .inv_valid(inv_valid), .inv_pc(inv_pc)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    function automatic logic [31:0] mkpc(input int idx, input int hi);
        return {hi[21:0], idx[7:0], 2'b00};
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare one slot against the model (R4 encoding: use = cnt>=2, const = cnt==3)
    task automatic chk(input int idx, input int hi, input string req);
        lk_pc = mkpc(idx, hi);
        #1;
        cmp(req, "value", lk_value, val_m[idx]);
        cmp(req, "use",   {31'd0, lk_use},   {31'd0, cnt_m[idx] >= 2});
        cmp(req, "const", {31'd0, lk_const}, {31'd0, cnt_m[idx] == 3});
    endtask

    function automatic int step(input int c, input bit hit);
        if (hit) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // One cycle of requests; model applied per R2, R3, R6
    task automatic op(input bit dv, input int vi, input logic [31:0] vv,
                      input bit di, input int ii, input int hi);
        vf_valid  = dv;
        vf_pc     = mkpc(vi, hi);
        vf_value  = vv;
        inv_valid = di;
        inv_pc    = mkpc(ii, hi + 5);
        @(posedge clk);
        if (dv) begin
            cnt_m[vi] = step(cnt_m[vi], val_m[vi] == vv);
            val_m[vi] = vv;
        end
        if (di) cnt_m[ii] = 1;
        @(negedge clk);
        vf_valid  = 1'b0;
        inv_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            cnt_m[i] = 0;
            val_m[i] = '0;
        end
        // Requests during the sweep must be ignored (R8)
        vf_valid  = 1'b1;
        vf_pc     = mkpc(5, 0);
        vf_value  = 32'hdead_beef;
        inv_valid = 1'b1;
        inv_pc    = mkpc(6, 0);
        repeat (3) @(negedge clk);
        lk_pc = mkpc(5, 0);
        #1;
        cmp("R8", "ready in reset", {31'd0, ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (255) @(posedge clk);
        @(negedge clk);
        lk_pc = mkpc(5, 0);
        #1;
        cmp("R7", "ready after 255 edges", {31'd0, ready}, 32'd0);
        cmp("R8", "value in sweep", lk_value, 32'd0);
        cmp("R8", "use in sweep", {31'd0, lk_use}, 32'd0);
        @(posedge clk);
        vf_valid  = 1'b0;
        inv_valid = 1'b0;
        @(negedge clk);
        cmp("R7", "ready after 256 edges", {31'd0, ready}, 32'd1);

        // R7 and R8: every slot cleared, sweep-time requests left no trace
        for (int i = 0; i < SLOTS; i++) chk(i, i, "R7");

        // R3/R4 ramp in every slot, R5 neighbour untouched
        for (int i = 0; i < SLOTS; i++) begin
            logic [31:0] v;
            v = 32'h1000_0000 + 32'(i * 3);
            op(1'b1, i, v, 1'b0, 0, i);
            chk(i, 1, "R3");
            for (int k = 0; k < 3; k++) begin
                op(1'b1, i, v, 1'b0, 0, k);
                chk(i, 2, "R4");
            end
            chk((i + 1) % SLOTS, 0, "R5");
        end

        // R1: aliasing through upper address bits
        for (int i = 0; i < SLOTS; i += 17) chk(i, i * 3 + 1, "R1");
        op(1'b1, 7, 32'h0000_0077, 1'b0, 0, 999);
        chk(7, 12345, "R1");
        chk(7, 0, "R2");

        // R3: descend and saturate at zero
        op(1'b1, 10, 32'h5, 1'b0, 0, 0);  chk(10, 0, "R3");
        op(1'b1, 10, 32'h6, 1'b0, 0, 0);  chk(10, 0, "R3");
        op(1'b1, 10, 32'h7, 1'b0, 0, 0);  chk(10, 0, "R3");
        op(1'b1, 10, 32'h8, 1'b0, 0, 0);  chk(10, 0, "R3");
        op(1'b1, 10, 32'h8, 1'b0, 0, 0);  chk(10, 0, "R3");

        // R6: invalidate alone, with same-slot verify, with other-slot verify
        op(1'b0, 0, 0, 1'b1, 20, 0);                  chk(20, 0, "R6");
        op(1'b1, 30, val_m[30], 1'b1, 30, 0);         chk(30, 0, "R6");
        op(1'b1, 30, 32'habc, 1'b1, 30, 0);           chk(30, 0, "R6");
        op(1'b1, 41, val_m[41], 1'b1, 40, 0);
        chk(40, 0, "R6");
        chk(41, 0, "R5");

        // Mixed traffic on a few slots with small values to force hits
        for (int n = 0; n < 3000; n++) begin
            int vi, ii;
            bit dv, di;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            vi = int'(lfsr[3:0]) * 16;
            ii = int'(lfsr[7:4]) * 16;
            dv = lfsr[8] | lfsr[9];
            di = lfsr[10] & lfsr[11] & lfsr[12];
            op(dv, vi, {30'd0, lfsr[14:13] & {1'b0, lfsr[15]}}, di, ii, n);
            chk(vi, n, "R3");
            chk(ii, n, "R6");
        end

        finish_run();
    end

endmodule